// File: doc/BRIEF.md
# Retrying Bus Target for a Slow Register Space

This block is a memory-mapped bus target placed in front of an internal register space that takes many clock cycles to answer. The target never stalls the bus. Every request that falls inside its address window gets a response exactly one cycle later, and that response is either okay or retry. When the data is not yet at hand, the requester must issue the same request again later.

A read that misses starts a single internal fetch and is answered with retry. The fetched word goes into a read-holding register that carries the address it came from. A later read to that address completes with the held word, and that read empties the register. A write is posted at once when the internal engine is idle, and it commits after a fixed delay. A write that arrives while the engine is busy is retried. The internal engine runs one operation at a time, either a fetch or a commit. A fetch never begins while a write is still committing, so a read always returns the most recently accepted write.

The fetch latency, the commit latency and the time a filled holding register is reserved for its own address are parameters given in clock cycles.

Top module: `dly_retry_target`

## Requirements
- R1: A request whose address bits above the 4 KB window offset differ from the window base receives no response (`rsp_vld` stays low) and starts no internal read or write.
- R2: A request inside the window receives exactly one response, with `rsp_vld` high in the cycle after the request is sampled. `rsp_code` 0 means okay and 1 means retry.
- R3: A read that does not match a filled holding register is retried. If the engine is idle, the read starts a fetch of word address `req_addr[11:2]` on the internal read port, which stays enabled for RD_LAT cycles. Repeating that read every cycle gives exactly RD_LAT+1 retries, and the next read completes okay.
- R4: A read whose word address matches the filled holding register completes okay with the fetched word and empties the register. The next read to that address is retried and starts a new fetch.
- R5: While a fetch is in flight, a read to any other address is retried. It does not restart the fetch or change its address.
- R6: A write that finds the engine idle completes okay at once. Its data is written to the internal port after WR_LAT cycles. A second write issued every cycle after it is retried exactly WR_LAT times, and is then accepted.
- R7: A write that arrives while a fetch or a commit is in progress is retried and is never committed. The internal read and write strobes are never active together.
- R8: An accepted write to the address held in the filled holding register empties that register. The next read of that address fetches again and returns the written value.
- R9: A filled holding register is reserved for its own address for HOLD_TMO cycles. During that time a read to another address is retried without starting a fetch. After that time, such a read discards the held word and starts a fetch of its own address.
- R10: While reset is high, and in the cycle after it, `rsp_vld`, `int_rd_en` and `int_we` are low.
- R11: `rsp_rdata` is zero on every retry response and on every write response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | BUS_AW | Byte address of the request |
| req_wdata | input | DW | Write data |
| rsp_vld | output | 1 | Response present (one cycle after the request) |
| rsp_code | output | 1 | 0 = okay, 1 = retry |
| rsp_rdata | output | DW | Read data on an okay read, zero otherwise |
| int_rd_en | output | 1 | Internal fetch in progress |
| int_raddr | output | WA | Word address being fetched |
| int_rdata | input | DW | Internal read data, captured in the last fetch cycle |
| int_we | output | 1 | One-cycle internal write strobe |
| int_waddr | output | WA | Internal write word address |
| int_wdata | output | DW | Internal write data |

## Verification
The bench builds the target with RD_LAT=6, WR_LAT=5 and HOLD_TMO=20 instead of latencies sized for a microsecond. With these values, the exact retry counts for a fetch and for a committing write can be checked within a few dozen cycles. The reservation window of the holding register can be crossed both before and after it expires. A short latency also lets a random mix of reads, writes and out-of-window requests cycle the engine many times, so reads keep landing on fetches in flight, on filled holding registers and on pending commits.

// File: rtl/dr_pkg.sv
package dr_pkg;

    typedef enum logic {
        RSP_OKAY  = 1'b0,
        RSP_RETRY = 1'b1
    } rsp_code_e;

    typedef enum logic [1:0] {
        ENG_IDLE   = 2'd0,
        ENG_FETCH  = 2'd1,
        ENG_COMMIT = 2'd2
    } eng_state_e;

    typedef struct packed {
        logic respond;
        logic retry;
        logic take_hold;
        logic start_rd;
        logic start_wr;
        logic inval;
    } dr_action_t;

    // Per-request decision of the target from engine and holding state.
    function automatic dr_action_t decide(
        input logic sel,
        input logic we,
        input logic eng_idle,
        input logic hold_valid,
        input logic hold_match,
        input logic hold_stale
    );
        dr_action_t a;
        a = '0;
        a.respond = sel;
        if (sel) begin
            if (we) begin
                if (eng_idle) begin
                    a.start_wr = 1'b1;
                    a.inval    = hold_match;
                end else begin
                    a.retry = 1'b1;
                end
            end else if (hold_match) begin
                a.take_hold = 1'b1;
            end else begin
                a.retry    = 1'b1;
                a.start_rd = eng_idle && (!hold_valid || hold_stale);
            end
        end
        return a;
    endfunction

endpackage

// File: rtl/dr_decode.sv
module dr_decode #(
    parameter int          BUS_AW   = 32,
    parameter int          WIN_LOG2 = 12,
    parameter int          BYTE_OFS = 2,
    parameter logic [31:0] WIN_BASE = 32'h4000_0000
) (
    input  logic                         req_vld,
    input  logic [BUS_AW-1:0]            req_addr,
    output logic                         sel,
    output logic [WIN_LOG2-BYTE_OFS-1:0] word_addr
);
    localparam logic [BUS_AW-1:0] BASE_W = BUS_AW'(WIN_BASE);

    logic unused_lsb;

    assign sel        = req_vld && (req_addr[BUS_AW-1:WIN_LOG2] == BASE_W[BUS_AW-1:WIN_LOG2]);
    assign word_addr  = req_addr[WIN_LOG2-1:BYTE_OFS];
    assign unused_lsb = ^req_addr[BYTE_OFS-1:0];
endmodule

// File: rtl/dr_engine.sv
module dr_engine
    import dr_pkg::*;
#(
    parameter int WA     = 10,
    parameter int DW     = 32,
    parameter int RD_LAT = 200,
    parameter int WR_LAT = 200
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_rd,
    input  logic          start_wr,
    input  logic [WA-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          idle,
    output logic          fetch_done,
    output logic          int_rd_en,
    output logic [WA-1:0] int_raddr,
    output logic          int_we,
    output logic [WA-1:0] int_waddr,
    output logic [DW-1:0] int_wdata
);
    localparam int MAX_LAT = (RD_LAT > WR_LAT) ? RD_LAT : WR_LAT;
    localparam int CNT_W   = $clog2(MAX_LAT + 1);

    eng_state_e       st;
    logic [CNT_W-1:0] cnt;
    logic             last;

    assign last = (cnt == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ENG_IDLE;
            cnt       <= '0;
            int_raddr <= '0;
            int_waddr <= '0;
            int_wdata <= '0;
        end else begin
            case (st)
                ENG_IDLE: begin
                    if (start_rd) begin
                        st        <= ENG_FETCH;
                        cnt       <= CNT_W'(RD_LAT);
                        int_raddr <= addr;
                    end else if (start_wr) begin
                        st        <= ENG_COMMIT;
                        cnt       <= CNT_W'(WR_LAT);
                        int_waddr <= addr;
                        int_wdata <= wdata;
                    end
                end
                ENG_FETCH, ENG_COMMIT: begin
                    cnt <= cnt - CNT_W'(1);
                    if (last) st <= ENG_IDLE;
                end
                default: st <= ENG_IDLE;
            endcase
        end
    end

    assign idle       = (st == ENG_IDLE);
    assign int_rd_en  = (st == ENG_FETCH);
    assign fetch_done = (st == ENG_FETCH) && last;
    assign int_we     = (st == ENG_COMMIT) && last;
endmodule

// File: rtl/dr_hold.sv
module dr_hold #(
    parameter int WA       = 10,
    parameter int DW       = 32,
    parameter int HOLD_TMO = 1024
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fetch_start,
    input  logic [WA-1:0] start_addr,
    input  logic          fetch_done,
    input  logic [DW-1:0] fill_data,
    input  logic          consume,
    input  logic          inval,
    input  logic [WA-1:0] look_addr,
    output logic          valid,
    output logic          match,
    output logic          stale,
    output logic [DW-1:0] data
);
    localparam int AGE_W = $clog2(HOLD_TMO + 1);

    logic [WA-1:0]    tag;
    logic [AGE_W-1:0] age;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            tag   <= '0;
            data  <= '0;
            age   <= '0;
        end else if (fetch_start) begin
            valid <= 1'b0;
            tag   <= start_addr;
        end else if (fetch_done) begin
            valid <= 1'b1;
            data  <= fill_data;
            age   <= '0;
        end else if (consume || inval) begin
            valid <= 1'b0;
        end else if (valid && (age != AGE_W'(HOLD_TMO))) begin
            age <= age + AGE_W'(1);
        end
    end

    assign match = valid && (tag == look_addr);
    assign stale = (age == AGE_W'(HOLD_TMO));
endmodule

// File: rtl/dly_retry_target.sv
module dly_retry_target
    import dr_pkg::*;
#(
    parameter int          BUS_AW   = 32,
    parameter int          DW       = 32,
    parameter int          WIN_LOG2 = 12,
    parameter logic [31:0] WIN_BASE = 32'h4000_0000,
    parameter int          RD_LAT   = 200,
    parameter int          WR_LAT   = 200,
    parameter int          HOLD_TMO = 1024,
    localparam int         BYTE_OFS = $clog2(DW / 8),
    localparam int         WA       = WIN_LOG2 - BYTE_OFS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_vld,
    input  logic              req_we,
    input  logic [BUS_AW-1:0] req_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic              rsp_vld,
    output logic              rsp_code,
    output logic [DW-1:0]     rsp_rdata,
    output logic              int_rd_en,
    output logic [WA-1:0]     int_raddr,
    input  logic [DW-1:0]     int_rdata,
    output logic              int_we,
    output logic [WA-1:0]     int_waddr,
    output logic [DW-1:0]     int_wdata
);
    logic          sel;
    logic [WA-1:0] waddr;
    logic          eng_idle;
    logic          fetch_done;
    logic          h_valid;
    logic          h_match;
    logic          h_stale;
    logic [DW-1:0] h_data;
    dr_action_t    act;

    dr_decode #(
        .BUS_AW  (BUS_AW),
        .WIN_LOG2(WIN_LOG2),
        .BYTE_OFS(BYTE_OFS),
        .WIN_BASE(WIN_BASE)
    ) dec_i (
        .req_vld  (req_vld),
        .req_addr (req_addr),
        .sel      (sel),
        .word_addr(waddr)
    );

    always_comb begin
        act = decide(sel, req_we, eng_idle, h_valid, h_match, h_stale);
    end

    dr_engine #(
        .WA    (WA),
        .DW    (DW),
        .RD_LAT(RD_LAT),
        .WR_LAT(WR_LAT)
    ) eng_i (
        .clk       (clk),
        .rst       (rst),
        .start_rd  (act.start_rd),
        .start_wr  (act.start_wr),
        .addr      (waddr),
        .wdata     (req_wdata),
        .idle      (eng_idle),
        .fetch_done(fetch_done),
        .int_rd_en (int_rd_en),
        .int_raddr (int_raddr),
        .int_we    (int_we),
        .int_waddr (int_waddr),
        .int_wdata (int_wdata)
    );

    dr_hold #(
        .WA      (WA),
        .DW      (DW),
        .HOLD_TMO(HOLD_TMO)
    ) hold_i (
        .clk        (clk),
        .rst        (rst),
        .fetch_start(act.start_rd),
        .start_addr (waddr),
        .fetch_done (fetch_done),
        .fill_data  (int_rdata),
        .consume    (act.take_hold),
        .inval      (act.inval),
        .look_addr  (waddr),
        .valid      (h_valid),
        .match      (h_match),
        .stale      (h_stale),
        .data       (h_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_vld   <= 1'b0;
            rsp_code  <= RSP_OKAY;
            rsp_rdata <= '0;
        end else begin
            rsp_vld   <= act.respond;
            rsp_code  <= act.retry ? RSP_RETRY : RSP_OKAY;
            rsp_rdata <= act.take_hold ? h_data : '0;
        end
    end
endmodule

// File: rtl/dr_chk.sv
module dr_chk #(
    parameter int          BUS_AW   = 32,
    parameter int          DW       = 32,
    parameter int          WIN_LOG2 = 12,
    parameter logic [31:0] WIN_BASE = 32'h4000_0000,
    parameter int          WA       = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              req_vld,
    input logic [BUS_AW-1:0] req_addr,
    input logic              rsp_vld,
    input logic              rsp_code,
    input logic [DW-1:0]     rsp_rdata,
    input logic              int_rd_en,
    input logic [WA-1:0]     int_raddr,
    input logic              int_we
);
    localparam logic [BUS_AW-1:0] BASE_W = BUS_AW'(WIN_BASE);

    logic inwin;
    assign inwin = req_vld && (req_addr[BUS_AW-1:WIN_LOG2] == BASE_W[BUS_AW-1:WIN_LOG2]);

    p_rsp_next_r2: assert property (@(posedge clk) disable iff (rst)
        inwin |=> rsp_vld);

    p_no_rsp_outside_r1: assert property (@(posedge clk) disable iff (rst)
        !inwin |=> !rsp_vld);

    p_retry_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (rsp_vld && rsp_code) |-> (rsp_rdata == '0));

    p_port_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(int_we && int_rd_en));

    p_raddr_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (int_rd_en && $past(int_rd_en)) |-> $stable(int_raddr));

    p_reset_quiet_r10: assert property (@(posedge clk)
        rst |=> (!rsp_vld && !int_rd_en && !int_we));
endmodule

bind dly_retry_target dr_chk #(
    .BUS_AW  (BUS_AW),
    .DW      (DW),
    .WIN_LOG2(WIN_LOG2),
    .WIN_BASE(WIN_BASE),
    .WA      (WA)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .req_vld  (req_vld),
    .req_addr (req_addr),
    .rsp_vld  (rsp_vld),
    .rsp_code (rsp_code),
    .rsp_rdata(rsp_rdata),
    .int_rd_en(int_rd_en),
    .int_raddr(int_raddr),
    .int_we   (int_we)
);

// File: tb/dly_retry_target_tb_top.sv
`timescale 1ns/1ps
module dly_retry_target_tb_top;
    localparam int          RD_LAT = 6;
    localparam int          WR_LAT = 5;
    localparam int          HOLD   = 20;
    localparam logic [31:0] BASE   = 32'h4000_0000;
    localparam int          WORDS  = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_vld = 1'b0;
    logic        req_we = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_vld;
    logic        rsp_code;
    logic [31:0] rsp_rdata;
    logic        int_rd_en;
    logic [9:0]  int_raddr;
    logic [31:0] int_rdata;
    logic        int_we;
    logic [9:0]  int_waddr;
    logic [31:0] int_wdata;

    logic [31:0] slow_mem [0:WORDS-1];
    logic [31:0] exp_mem  [0:WORDS-1];

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    int          fetch_starts = 0;
    int          commits      = 0;
    logic [9:0]  last_fetch   = '0;
    logic        prev_rd      = 1'b0;

    logic        got_vld;
    logic        got_code;
    logic [31:0] got_data;

    always #2.5 clk = ~clk;

    dly_retry_target #(
        .RD_LAT  (RD_LAT),
        .WR_LAT  (WR_LAT),
        .HOLD_TMO(HOLD),
        .WIN_BASE(BASE)
    ) dut_i (
        .clk      (clk),
        .rst      (rst),
        .req_vld  (req_vld),
        .req_we   (req_we),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .rsp_vld  (rsp_vld),
        .rsp_code (rsp_code),
        .rsp_rdata(rsp_rdata),
        .int_rd_en(int_rd_en),
        .int_raddr(int_raddr),
        .int_rdata(int_rdata),
        .int_we   (int_we),
        .int_waddr(int_waddr),
        .int_wdata(int_wdata)
    );

    // Slow register model and port monitors
    assign int_rdata = slow_mem[int_raddr];

    always @(posedge clk) begin
        prev_rd <= int_rd_en;
        if (int_rd_en && !prev_rd) begin
            fetch_starts <= fetch_starts + 1;
            last_fetch   <= int_raddr;
        end
        if (int_we) begin
            slow_mem[int_waddr] <= int_wdata;
            commits <= commits + 1;
        end
    end

    function automatic logic [31:0] wa(input int w);
        return BASE | (32'(w) << 2);
    endfunction

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // Issue one request at a negedge, sample its response one cycle later.
    task automatic req(input bit we, input logic [31:0] a, input logic [31:0] d);
        req_vld   = 1'b1;
        req_we    = we;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        got_vld  = rsp_vld;
        got_code = rsp_code;
        got_data = rsp_rdata;
        req_vld  = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    int  lp_retries;
    bit  lp_proto_bad;

    task automatic rd_loop(input logic [31:0] a);
        lp_retries   = 0;
        lp_proto_bad = 1'b0;
        for (int k = 0; k < 200; k++) begin
            req(1'b0, a, '0);
            if (!got_vld) lp_proto_bad = 1'b1;
            if (got_code == 1'b0) break;
            if (got_data != 0) lp_proto_bad = 1'b1;
            lp_retries++;
        end
    endtask

    task automatic wr_loop(input logic [31:0] a, input logic [31:0] d);
        lp_retries   = 0;
        lp_proto_bad = 1'b0;
        for (int k = 0; k < 200; k++) begin
            req(1'b1, a, d);
            if (!got_vld || got_data != 0) lp_proto_bad = 1'b1;
            if (got_code == 1'b0) break;
            lp_retries++;
        end
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        int fs;
        int cm;
        logic [31:0] v;
        void'($urandom(32'd5171));
        for (int i = 0; i < WORDS; i++) begin
            v = $urandom;
            slow_mem[i] = v;
            exp_mem[i]  = v;
        end

        idle(4);
        // R10: quiet outputs in reset
        check(!rsp_vld && !int_rd_en && !int_we, "R10", "reset outputs",
              {29'd0, rsp_vld, int_rd_en, int_we}, 32'd0);
        rst = 1'b0;
        idle(2);

        // R1: out-of-window requests ignored
        fs = fetch_starts; cm = commits;
        req(1'b0, 32'h5000_0010, '0);
        check(!got_vld, "R1", "outside read response", {31'd0, got_vld}, 32'd0);
        req(1'b1, 32'h4000_1008, 32'hDEAD_BEEF);
        check(!got_vld, "R1", "outside write response", {31'd0, got_vld}, 32'd0);
        idle(WR_LAT + 3);
        check(fetch_starts == fs && commits == cm, "R1", "internal activity",
              32'(fetch_starts - fs + commits - cm), 32'd0);

        // R3/R2/R11: miss, retries, completion
        fs = fetch_starts;
        rd_loop(wa(5));
        check(lp_retries == RD_LAT + 1, "R3", "retry count", 32'(lp_retries), 32'(RD_LAT + 1));
        check(got_data == exp_mem[5], "R4", "held data", got_data, exp_mem[5]);
        check(fetch_starts == fs + 1 && last_fetch == 10'd5, "R3", "fetch address",
              {22'd0, last_fetch}, 32'd5);
        check(!lp_proto_bad, "R2", "response every cycle / zero retry data",
              {31'd0, lp_proto_bad}, 32'd0);

        // R4: consumed register empties
        fs = fetch_starts;
        req(1'b0, wa(5), '0);
        check(got_vld && got_code == 1'b1, "R4", "re-read after consume", {31'd0, got_code}, 32'd1);
        idle(1);
        check(fetch_starts == fs + 1, "R4", "refetch started", 32'(fetch_starts - fs), 32'd1);
        rd_loop(wa(5));
        check(got_data == exp_mem[5], "R4", "refetch data", got_data, exp_mem[5]);

        // R5: other address during fetch
        fs = fetch_starts;
        req(1'b0, wa(7), '0);
        req(1'b0, wa(9), '0);
        check(got_code == 1'b1, "R5", "other read retried", {31'd0, got_code}, 32'd1);
        idle(1);
        check(fetch_starts == fs + 1 && last_fetch == 10'd7, "R5", "fetch not restarted",
              {22'd0, last_fetch}, 32'd7);
        rd_loop(wa(7));
        check(got_data == exp_mem[7], "R5", "original read data", got_data, exp_mem[7]);

        // R6: posted write and back-to-back write
        cm = commits;
        wr_loop(wa(12), 32'h1234_5678);
        check(lp_retries == 0, "R6", "first write immediate", 32'(lp_retries), 32'd0);
        exp_mem[12] = 32'h1234_5678;
        wr_loop(wa(13), 32'h9ABC_DEF0);
        check(lp_retries == WR_LAT, "R6", "second write retries", 32'(lp_retries), 32'(WR_LAT));
        exp_mem[13] = 32'h9ABC_DEF0;
        idle(WR_LAT + 2);
        check(slow_mem[12] == exp_mem[12] && slow_mem[13] == exp_mem[13], "R6", "committed data",
              slow_mem[13], exp_mem[13]);
        check(commits == cm + 2, "R6", "commit count", 32'(commits - cm), 32'd2);
        check(!lp_proto_bad, "R11", "write response data", {31'd0, lp_proto_bad}, 32'd0);

        // R7: write during fetch
        cm = commits;
        req(1'b0, wa(20), '0);
        req(1'b1, wa(21), 32'h0BAD_0BAD);
        check(got_code == 1'b1 && got_data == 0, "R7", "write during fetch", {31'd0, got_code}, 32'd1);
        rd_loop(wa(20));
        idle(WR_LAT + 3);
        check(commits == cm && slow_mem[21] == exp_mem[21], "R7", "retried write not committed",
              slow_mem[21], exp_mem[21]);

        // R8: write invalidates held word
        req(1'b0, wa(30), '0);
        idle(RD_LAT + 2);
        wr_loop(wa(30), 32'hCAFE_F00D);
        check(lp_retries == 0, "R8", "write accepted", 32'(lp_retries), 32'd0);
        exp_mem[30] = 32'hCAFE_F00D;
        idle(WR_LAT + 2);
        rd_loop(wa(30));
        check(lp_retries == RD_LAT + 1, "R8", "refetch retries", 32'(lp_retries), 32'(RD_LAT + 1));
        check(got_data == 32'hCAFE_F00D, "R8", "new value", got_data, 32'hCAFE_F00D);

        // R9: reservation window
        req(1'b0, wa(40), '0);
        idle(RD_LAT + 2);
        fs = fetch_starts;
        req(1'b0, wa(41), '0);
        idle(1);
        check(got_code == 1'b1 && fetch_starts == fs, "R9", "reserved, no fetch",
              32'(fetch_starts - fs), 32'd0);
        idle(HOLD + 2);
        req(1'b0, wa(41), '0);
        idle(1);
        check(fetch_starts == fs + 1 && last_fetch == 10'd41, "R9", "stale discarded",
              {22'd0, last_fetch}, 32'd41);
        rd_loop(wa(41));
        check(got_data == exp_mem[41], "R9", "new fetch data", got_data, exp_mem[41]);
        rd_loop(wa(40));
        check(lp_retries == RD_LAT + 1 && got_data == exp_mem[40], "R9", "discarded word refetched",
              got_data, exp_mem[40]);

        // Random mix: R1/R3/R4/R6
        for (int n = 0; n < 80; n++) begin
            int w;
            int op;
            logic [31:0] d;
            w  = int'($urandom_range(0, 15));
            op = int'($urandom_range(0, 9));
            d  = $urandom;
            if (op < 5) begin
                rd_loop(wa(w));
                check(got_vld && got_code == 1'b0 && got_data == exp_mem[w], "R4",
                      "random read data", got_data, exp_mem[w]);
            end else if (op < 9) begin
                wr_loop(wa(w), d);
                check(got_code == 1'b0 && !lp_proto_bad, "R6", "random write accepted",
                      {31'd0, got_code}, 32'd0);
                exp_mem[w] = d;
            end else begin
                req(op[0], 32'h8000_0000 | (32'(w) << 2), d);
                check(!got_vld, "R1", "random outside request", {31'd0, got_vld}, 32'd0);
            end
            idle(int'($urandom_range(0, 8)));
        end
        idle(WR_LAT + 2);
        for (int w = 0; w < 16; w++) begin
            check(slow_mem[w] == exp_mem[w], "R6", "final register content", slow_mem[w], exp_mem[w]);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule